// File: doc/BRIEF.md
# Serial Pattern Checker with Lock Tracking and Measurement Counters

This block is the receive half of a bit-error-rate test engine. A serial bit arrives on each clock cycle in which the enable is high. It can be inverted on entry. It is then matched against a locally regenerated pseudorandom reference.

The block first seeds the reference from the line itself. It then confirms the seed over a run of matching bits, and from that point tracks lock. While locked, every enabled bit is counted, and every bit that disagrees with the prediction is also counted as an error. Lock is abandoned when errors cluster too densely, and the block then reacquires without outside help.

Software-facing control is reduced to two level inputs that act only on their rising edges. One edge takes a coherent snapshot of both counters into holding registers and restarts the measurement. The other edge discards lock and restarts acquisition.

Top module: `bert_rx_sync`

## Requirements
- R1: When `rx_inv` is 1 the incoming bit is complemented before seeding and comparison. A complemented stream with `rx_inv` = 0 never reaches lock.
- R2: `pat_sel` picks the recurrence b[n] = b[n-L] xor b[n-T]: 000 gives (L,T) = (7,6), 111 gives (9,5), 001 gives (11,9) and 010 gives (15,14). Any other code holds the block out of lock.
- R3: After a restart, the first L enabled bits are loaded into the reference. Lock then needs 32 consecutive matching enabled bits. `in_sync` rises on the clock edge that takes the 32nd of these bits. A mismatch during this confirmation run restarts loading.
- R4: While locked, a lock loss occurs when an error bit brings the count of errors to 6 or more among that bit and the previous 63 enabled bits. `in_sync` drops on the same edge and loading restarts. Five errors inside any such window keep lock.
- R5: The live counters advance only on enabled bits taken while `in_sync` is 1. The bit counter advances by one for each such bit. The error counter advances by one for each such bit that mismatches. With `rx_en` low or lock absent, nothing is counted.
- R6: A rising edge of `latch_req` copies both live counts into `bit_cnt_q` and `err_cnt_q`, visible after that edge. On the same edge both live counts restart from zero, and the bit taken on that edge is not counted. Between latch edges the outputs hold.
- R7: A rising edge of `resync_req` drops lock on that edge. It discards the bit on that edge and starts loading. The counters are left unchanged.
- R8: A control held high acts once. It must return low before it can act again.
- R9: Each live counter stops at its all-ones value instead of wrapping.
- R10: After reset, `in_sync`, `bit_cnt_q` and `err_cnt_q` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 1 | Received serial bit |
| rx_en | input | 1 | Marks a cycle that carries a valid bit |
| pat_sel | input | 3 | Pattern code (R2) |
| rx_inv | input | 1 | Complement incoming data |
| latch_req | input | 1 | Snapshot-and-clear request, rising edge |
| resync_req | input | 1 | Reacquire request, rising edge |
| bit_cnt_q | output | BIT_W (32) | Latched bit count |
| err_cnt_q | output | ERR_W (24) | Latched error count |
| in_sync | output | 1 | Lock status |

## Verification
A corrupted reference history appears at the ports one way during confirmation and another way after lock. During confirmation, `in_sync` fails to rise after exactly L+32 clean bits. After lock, errors pile up fast enough that `in_sync` falls within a few dozen bits. A wrong window count moves the loss edge by whole bits around the sixth clustered error, and the bench pins that edge to an exact cycle. Counter faults stay hidden until the next latch edge, where the snapshot differs from a count the bench builds independently of the design. A narrow second instance exposes the saturation limits within a few hundred bits.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;

   localparam int REF_MAX = 15;

   typedef enum logic [1:0] {
      SY_LOAD  = 2'd0,
      SY_CHECK = 2'd1,
      SY_LOCK  = 2'd2
   } sync_state_e;

   localparam logic [2:0] PAT_P7  = 3'b000;
   localparam logic [2:0] PAT_P11 = 3'b001;
   localparam logic [2:0] PAT_P15 = 3'b010;
   localparam logic [2:0] PAT_P9  = 3'b111;

   // register length; zero marks an unsupported code
   function automatic logic [4:0] pat_len(input logic [2:0] sel);
      case (sel)
         PAT_P7:  return 5'd7;
         PAT_P9:  return 5'd9;
         PAT_P11: return 5'd11;
         PAT_P15: return 5'd15;
         default: return 5'd0;
      endcase
   endfunction

   function automatic logic [4:0] pat_tap(input logic [2:0] sel);
      case (sel)
         PAT_P7:  return 5'd6;
         PAT_P9:  return 5'd5;
         PAT_P11: return 5'd9;
         PAT_P15: return 5'd14;
         default: return 5'd0;
      endcase
   endfunction

endpackage

// File: rtl/bert_rise_det.sv
module bert_rise_det #(
   parameter int NUM = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] lvl,
   output logic [NUM-1:0] rise
);
   generate
      if (NUM < 1) begin : g_bad
         $error("bert_rise_det: NUM must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < NUM; i++) begin : g_bit
      logic lvl_q;
      always_ff @(posedge clk) begin
         if (!rst_n) lvl_q <= 1'b0;
         else        lvl_q <= lvl[i];
      end
      assign rise[i] = lvl[i] & ~lvl_q;
   end
endmodule

// File: rtl/bert_prbs_ref.sv
module bert_prbs_ref #(
   parameter int REF_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             load,
   input  logic             din,
   input  logic [4:0]       len,
   input  logic [4:0]       tap,
   output logic             pred
);
   generate
      if (REF_W < 2 || REF_W > 31) begin : g_bad
         $error("bert_prbs_ref: REF_W out of range");
      end
   endgenerate

   logic [REF_W-1:0] hist_q;
   logic [REF_W-1:0] tap_mask;

   // hist_q[k] holds the bit received k+1 enabled bits ago
   always_comb begin
      tap_mask = '0;
      for (int k = 0; k < REF_W; k++) begin
         if ((len != 5'd0) && ((5'(k + 1) == len) || (5'(k + 1) == tap)))
            tap_mask[k] = 1'b1;
      end
   end

   assign pred = ^(hist_q & tap_mask);

   always_ff @(posedge clk) begin
      if (!rst_n)   hist_q <= '0;
      else if (adv) hist_q <= {hist_q[REF_W-2:0], (load ? din : pred)};
   end
endmodule

// File: rtl/bert_sync_ctrl.sv
module bert_sync_ctrl
   import bert_rx_pkg::*;
#(
   parameter int SYNC_RUN  = 32,
   parameter int WIN       = 64,
   parameter int LOSS_ERRS = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        restart,
   input  logic        bit_vld,
   input  logic        mismatch,
   input  logic [4:0]  len,
   output sync_state_e state
);
   localparam int RUN_W = $clog2(SYNC_RUN + 1);
   localparam int CNT_W = $clog2(WIN + 1);
   localparam int HST_W = WIN - 1;

   generate
      if (SYNC_RUN < 1) begin : g_bad_run
         $error("bert_sync_ctrl: SYNC_RUN must be positive");
      end
      if (WIN < 3) begin : g_bad_win
         $error("bert_sync_ctrl: WIN must be at least 3");
      end
      if (LOSS_ERRS < 1 || LOSS_ERRS > WIN) begin : g_bad_loss
         $error("bert_sync_ctrl: LOSS_ERRS must lie in 1..WIN");
      end
   endgenerate

   sync_state_e      state_q;
   logic [4:0]       ld_cnt_q;
   logic [RUN_W-1:0] run_q;
   logic [HST_W-1:0] ehist_q;   // error flags of the previous WIN-1 locked bits
   logic [CNT_W-1:0] ecnt_q;    // population of ehist_q
   logic [CNT_W-1:0] ecnt_now;
   logic             lose;

   assign ecnt_now = ecnt_q + CNT_W'(mismatch);
   assign lose     = (ecnt_now >= CNT_W'(LOSS_ERRS));
   assign state    = state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SY_LOAD;
         ld_cnt_q <= '0;
         run_q    <= '0;
         ehist_q  <= '0;
         ecnt_q   <= '0;
      end else if (restart) begin
         state_q  <= SY_LOAD;
         ld_cnt_q <= '0;
      end else if (bit_vld) begin
         case (state_q)
            SY_LOAD: begin
               if (ld_cnt_q == len - 5'd1) begin
                  state_q <= SY_CHECK;
                  run_q   <= '0;
               end else begin
                  ld_cnt_q <= ld_cnt_q + 5'd1;
               end
            end
            SY_CHECK: begin
               if (mismatch) begin
                  state_q  <= SY_LOAD;
                  ld_cnt_q <= '0;
               end else if (run_q == RUN_W'(SYNC_RUN - 1)) begin
                  state_q <= SY_LOCK;
                  ehist_q <= '0;
                  ecnt_q  <= '0;
               end else begin
                  run_q <= run_q + RUN_W'(1);
               end
            end
            SY_LOCK: begin
               if (lose) begin
                  state_q  <= SY_LOAD;
                  ld_cnt_q <= '0;
               end else begin
                  ehist_q <= {ehist_q[HST_W-2:0], mismatch};
                  ecnt_q  <= ecnt_now - CNT_W'(ehist_q[HST_W-1]);
               end
            end
            default: begin
               state_q  <= SY_LOAD;
               ld_cnt_q <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/bert_sat_cnt.sv
module bert_sat_cnt #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   generate
      if (W < 2) begin : g_bad
         $error("bert_sat_cnt: W must be at least 2");
      end
   endgenerate

   logic at_max;
   assign at_max = &q;

   always_ff @(posedge clk) begin
      if (!rst_n)                q <= '0;
      else if (clr)              q <= '0;
      else if (inc && !at_max)   q <= q + W'(1);
   end
endmodule

// File: rtl/bert_rx_sync.sv
module bert_rx_sync
   import bert_rx_pkg::*;
#(
   parameter int BIT_W     = 32,
   parameter int ERR_W     = 24,
   parameter int SYNC_RUN  = 32,
   parameter int WIN       = 64,
   parameter int LOSS_ERRS = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_data,
   input  logic             rx_en,
   input  logic [2:0]       pat_sel,
   input  logic             rx_inv,
   input  logic             latch_req,
   input  logic             resync_req,
   output logic [BIT_W-1:0] bit_cnt_q,
   output logic [ERR_W-1:0] err_cnt_q,
   output logic             in_sync
);
   localparam int CTL_N = 2;

   generate
      if (ERR_W > BIT_W) begin : g_bad_w
         $error("bert_rx_sync: ERR_W must not exceed BIT_W");
      end
   endgenerate

   logic [CTL_N-1:0] ctl_rise;
   logic             latch_edge;
   logic             resync_edge;
   logic             rx_bit;
   logic [4:0]       len;
   logic [4:0]       tap;
   logic             supported;
   logic             bit_vld;
   logic             pred;
   logic             mismatch;
   sync_state_e      state;
   logic             count_bit;
   logic [BIT_W-1:0] live_bits;
   logic [ERR_W-1:0] live_errs;

   bert_rise_det #(.NUM(CTL_N)) u_rise (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  ({resync_req, latch_req}),
      .rise (ctl_rise)
   );

   assign latch_edge  = ctl_rise[0];
   assign resync_edge = ctl_rise[1];
   assign rx_bit      = rx_data ^ rx_inv;
   assign len         = pat_len(pat_sel);
   assign tap         = pat_tap(pat_sel);
   assign supported   = (len != 5'd0);
   assign bit_vld     = rx_en & ~resync_edge;
   assign mismatch    = rx_bit ^ pred;

   bert_prbs_ref #(.REF_W(REF_MAX)) u_ref (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (bit_vld),
      .load (state == SY_LOAD),
      .din  (rx_bit),
      .len  (len),
      .tap  (tap),
      .pred (pred)
   );

   bert_sync_ctrl #(
      .SYNC_RUN (SYNC_RUN),
      .WIN      (WIN),
      .LOSS_ERRS(LOSS_ERRS)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (resync_edge | ~supported),
      .bit_vld (bit_vld),
      .mismatch(mismatch),
      .len     (len),
      .state   (state)
   );

   assign in_sync   = (state == SY_LOCK);
   assign count_bit = bit_vld & in_sync;

   bert_sat_cnt #(.W(BIT_W)) u_bits (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (latch_edge),
      .inc  (count_bit),
      .q    (live_bits)
   );

   bert_sat_cnt #(.W(ERR_W)) u_errs (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (latch_edge),
      .inc  (count_bit & mismatch),
      .q    (live_errs)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_cnt_q <= '0;
         err_cnt_q <= '0;
      end else if (latch_edge) begin
         bit_cnt_q <= live_bits;
         err_cnt_q <= live_errs;
      end
   end
endmodule

// File: rtl/bert_rx_sync_chk.sv
module bert_rx_sync_chk #(
   parameter int BIT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             latch_edge,
   input logic             resync_edge,
   input logic             in_sync,
   input logic [BIT_W-1:0] live_bits,
   input logic [BIT_W-1:0] bit_cnt_q
);
   // R5: nothing is counted out of lock
   p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_sync && !latch_edge) |=> $stable(live_bits));

   // R6: a latch edge restarts the live count
   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      latch_edge |=> (live_bits == '0));

   // R6: latched outputs move only on a latch edge
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_edge |=> $stable(bit_cnt_q));

   // R9: a full counter stays full
   p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((&live_bits) && !latch_edge) |=> (&live_bits));

   // R7: reacquire drops lock at once
   p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resync_edge |=> !in_sync);

   // R8: a held request yields a single action
   p_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      latch_edge |=> !latch_edge);
endmodule

bind bert_rx_sync bert_rx_sync_chk #(.BIT_W(BIT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .latch_edge (latch_edge),
   .resync_edge(resync_edge),
   .in_sync    (in_sync),
   .live_bits  (live_bits),
   .bit_cnt_q  (bit_cnt_q)
);

// File: tb/bert_rx_sync_tb.sv
module bert_rx_sync_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_data = 1'b0;
   logic        rx_en = 1'b0;
   logic [2:0]  pat_sel = 3'b000;
   logic        rx_inv = 1'b0;
   logic        latch_req = 1'b0;
   logic        resync_req = 1'b0;
   logic [31:0] bit_cnt_q;
   logic [23:0] err_cnt_q;
   logic        in_sync;
   logic [7:0]  s_bits;
   logic [3:0]  s_errs;
   logic        s_sync;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit cmp_on = 0;

   always #5 clk = ~clk;

   bert_rx_sync u_dut (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_en(rx_en),
      .pat_sel(pat_sel), .rx_inv(rx_inv), .latch_req(latch_req),
      .resync_req(resync_req), .bit_cnt_q(bit_cnt_q),
      .err_cnt_q(err_cnt_q), .in_sync(in_sync)
   );

   bert_rx_sync #(.BIT_W(8), .ERR_W(4)) u_dut_sat (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_en(rx_en),
      .pat_sel(pat_sel), .rx_inv(rx_inv), .latch_req(latch_req),
      .resync_req(resync_req), .bit_cnt_q(s_bits),
      .err_cnt_q(s_errs), .in_sync(s_sync)
   );

   task automatic check(input bit ok, input string tag,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic void pat_of(input logic [2:0] sel, output int l, output int t);
      case (sel)
         3'b000: begin l = 7;  t = 6;  end
         3'b111: begin l = 9;  t = 5;  end
         3'b001: begin l = 11; t = 9;  end
         3'b010: begin l = 15; t = 14; end
         default: begin l = 0; t = 0; end
      endcase
   endfunction

   function automatic longint sat(input longint v, input int w);
      longint mx = (longint'(1) << w) - 1;
      return (v > mx) ? mx : v;
   endfunction

   // ---------------- reference model built from the requirements ----------
   int          m_st;
   int          m_ld, m_run, m_wc;
   logic [14:0] m_h;
   logic [62:0] m_w;
   longint      m_lb, m_le, m_sb, m_se;
   logic        m_lq, m_rq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_ld = 0; m_run = 0; m_wc = 0; m_h = '0; m_w = '0;
         m_lb = 0; m_le = 0; m_sb = 0; m_se = 0; m_lq = 0; m_rq = 0;
      end else begin
         int l, t;
         logic le, re, d, vld, pr, mis;
         le = latch_req & ~m_lq;
         re = resync_req & ~m_rq;
         m_lq = latch_req;
         m_rq = resync_req;
         pat_of(pat_sel, l, t);
         d   = rx_data ^ rx_inv;
         vld = rx_en & ~re;
         pr  = (l == 0) ? 1'b0 : (m_h[l-1] ^ m_h[t-1]);
         mis = d ^ pr;
         if (le) begin
            m_sb = m_lb; m_se = m_le; m_lb = 0; m_le = 0;
         end else if (vld && m_st == 2) begin
            m_lb++;
            if (mis) m_le++;
         end
         if (vld) m_h = {m_h[13:0], (m_st == 0) ? d : pr};
         if (re || l == 0) begin
            m_st = 0; m_ld = 0;
         end else if (vld) begin
            case (m_st)
               0: if (m_ld == l - 1) begin m_st = 1; m_run = 0; end else m_ld++;
               1: if (mis) begin m_st = 0; m_ld = 0; end
                  else if (m_run == 31) begin m_st = 2; m_w = '0; m_wc = 0; end
                  else m_run++;
               default: begin
                  if (m_wc + int'(mis) >= 6) begin m_st = 0; m_ld = 0; end
                  else begin
                     m_wc = m_wc + int'(mis) - int'(m_w[62]);
                     m_w  = {m_w[61:0], mis};
                  end
               end
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_on && rst_n && !done) begin
         check(in_sync == (m_st == 2), "R3 R4 lock state", in_sync, m_st == 2);
         check(s_sync == (m_st == 2), "R3 lock state (narrow)", s_sync, m_st == 2);
         check(bit_cnt_q == sat(m_sb, 32), "R6 latched bits", bit_cnt_q, sat(m_sb, 32));
         check(err_cnt_q == sat(m_se, 24), "R6 latched errors", err_cnt_q, sat(m_se, 24));
         check(s_bits == sat(m_sb, 8), "R9 narrow bits", s_bits, sat(m_sb, 8));
         check(s_errs == sat(m_se, 4), "R9 narrow errors", s_errs, sat(m_se, 4));
      end
   end

   // ---------------- stimulus ----------------
   logic [14:0] g = 15'h1;
   int gl = 7, gt = 6;
   bit tx_inv = 0;

   task automatic step(input bit en, input bit flip);
      logic nb;
      if (en) begin
         nb = g[gl-1] ^ g[gt-1];
         g = {g[13:0], nb};
         rx_data = nb ^ flip ^ tx_inv;
         rx_en = 1'b1;
      end else begin
         rx_en = 1'b0;
         rx_data = 1'($urandom % 2);
      end
      @(negedge clk);
   endtask

   task automatic use_stream(input logic [2:0] code);
      int l, t;
      pat_of(code, l, t);
      gl = l; gt = t; g = 15'h1;
   endtask

   task automatic do_resync();
      resync_req = 1'b1; step(0, 0); resync_req = 1'b0; step(0, 0);
   endtask

   task automatic do_latch();
      latch_req = 1'b1; step(0, 0); latch_req = 1'b0; step(0, 0);
   endtask

   task automatic acquire(input logic [2:0] code);
      pat_sel = code; use_stream(code);
      do_resync();
      repeat (gl + 40) step(1, 0);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [2:0] codes [4] = '{3'b000, 3'b111, 3'b001, 3'b010};
      logic [31:0] held;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset values
      check(in_sync == 1'b0, "R10 in_sync after reset", in_sync, 0);
      check(bit_cnt_q == 0, "R10 bit count after reset", bit_cnt_q, 0);
      check(err_cnt_q == 0, "R10 error count after reset", err_cnt_q, 0);
      cmp_on = 1;

      // R3: exact acquisition length on 2^9-1
      pat_sel = 3'b111; use_stream(3'b111);
      do_resync();
      repeat (9 + 31) step(1, 0);
      check(in_sync == 1'b0, "R3 not locked one bit early", in_sync, 0);
      step(1, 0);
      check(in_sync == 1'b1, "R3 locked after L+32 bits", in_sync, 1);

      // R5: counting in lock, idle enable, errors
      do_latch();
      repeat (100) step(1, 0);
      do_latch();
      check(bit_cnt_q == 100, "R5 bits counted in lock", bit_cnt_q, 100);
      check(err_cnt_q == 0, "R5 clean stream no errors", err_cnt_q, 0);
      repeat (50) step(0, 0);
      do_latch();
      check(bit_cnt_q == 0, "R5 idle enable counts nothing", bit_cnt_q, 0);
      for (int i = 0; i < 60; i++) step(1, (i % 20) == 5);
      do_latch();
      check(err_cnt_q == 3, "R5 error count", err_cnt_q, 3);

      // R4: five errors inside a window keep lock, six drop it
      for (int i = 0; i < 50; i++) step(1, (i % 10) == 0);
      repeat (70) step(1, 0);
      for (int i = 0; i < 50; i++) step(1, (i % 10) == 0);
      check(in_sync == 1'b1, "R4 five errors keep lock", in_sync, 1);
      repeat (70) step(1, 0);
      for (int i = 0; i < 5; i++) begin step(1, 1); repeat (9) step(1, 0); end
      check(in_sync == 1'b1, "R4 lock before sixth error", in_sync, 1);
      step(1, 1);
      check(in_sync == 1'b0, "R4 sixth error drops lock", in_sync, 0);
      repeat (60) step(1, 0);
      check(in_sync == 1'b1, "R4 reacquired", in_sync, 1);

      // R7: resync drops lock, counts untouched
      do_latch();
      repeat (30) step(1, 0);
      resync_req = 1'b1; step(1, 0);
      check(in_sync == 1'b0, "R7 resync drops lock", in_sync, 0);
      resync_req = 1'b0;
      do_latch();
      check(bit_cnt_q == 30, "R7 counts kept over resync", bit_cnt_q, 30);

      // R8: held latch request acts once
      repeat (45) step(1, 0);
      latch_req = 1'b1; step(0, 0);
      held = bit_cnt_q;
      repeat (20) step(1, 0);
      check(bit_cnt_q == held, "R8 held request no second snapshot", bit_cnt_q, held);
      latch_req = 1'b0; step(0, 0);
      do_latch();
      check(bit_cnt_q == 20, "R8 counting continued while held", bit_cnt_q, 20);

      // R9: saturation on the narrow instance
      do_latch();
      for (int i = 0; i < 400; i++) step(1, (i % 16) == 3);
      do_latch();
      check(s_bits == 8'hFF, "R9 narrow bit count stops", s_bits, 255);
      check(s_errs == 4'hF, "R9 narrow error count stops", s_errs, 15);
      check(bit_cnt_q == 400, "R9 wide bit count", bit_cnt_q, 400);
      check(err_cnt_q == 25, "R9 wide error count", err_cnt_q, 25);

      // R2: unsupported code never locks
      pat_sel = 3'b100; use_stream(3'b000);
      do_resync();
      repeat (300) step(1, 0);
      check(in_sync == 1'b0, "R2 unsupported code stays unlocked", in_sync, 0);

      // R1: complemented stream without inversion never locks
      pat_sel = 3'b000; tx_inv = 1; rx_inv = 1'b0;
      do_resync();
      repeat (300) step(1, 0);
      check(in_sync == 1'b0, "R1 complemented stream rejected", in_sync, 0);

      // R1 R2: random traffic on each pattern, both polarities
      for (int p = 0; p < 4; p++) begin
         for (int v = 0; v < 2; v++) begin
            tx_inv = v[0]; rx_inv = v[0];
            acquire(codes[p]);
            check(in_sync == 1'b1, "R1 R2 lock on selected pattern", in_sync, 1);
            for (int i = 0; i < 1500; i++) begin
               if (($urandom % 250) == 0) latch_req = 1'b1;
               else if (($urandom % 4) == 0) latch_req = 1'b0;
               step(($urandom % 8) != 0, ($urandom % 120) == 0);
            end
            latch_req = 1'b0; step(0, 0);
            do_latch();
         end
      end
      tx_inv = 0; rx_inv = 1'b0;

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule